// File: doc/BRIEF.md
# Chroma Upsampler with Line Cache

This block takes chroma that is subsampled by two in both directions and turns it into one Cb/Cr pair for every output pixel of the frame. Chroma lines arrive as a valid/ready stream from the memory fetch side. The upsampled pairs leave as a valid/ready stream in raster order. A one-line cache keeps the most recently fetched chroma line. Output lines that need only that line are built from the cache, and lines that need two chroma lines combine the cache with the line arriving on the stream. Each chroma line is therefore fetched exactly once per frame.

The frame is `OUT_W` pixels wide, with `OUT_W` even, at least 4 and at most 1024. It is `2*CH_LINES` lines tall, and the chroma grid is `OUT_W/2` samples by `CH_LINES` lines.

Output lines follow a fixed schedule:
- Line 0 is interpolated horizontally from chroma line 0 while that line is streaming in.
- Odd lines, except the last one, each fetch the next chroma line and use a 2x2 kernel over the cached line and the new one.
- Even lines from 2 onward are built from the cache alone.
- The last line is built from the cache alone, which repeats the final chroma line.

A missing right-hand neighbour is replaced by the last sample of its line.

Top module: `chroma_upsampler`

## Requirements
- R1: Reset state. While reset is held, or before any input arrives, `out_valid` is 0 when `in_valid` is 0. `in_ready` equals `out_ready`, because the first pixel needs a stream sample.
- R2: Sample packing. Both streams carry Cb in bits [SW-1:0] and Cr in bits [2*SW-1:SW]. Each component is averaged on its own, and the Cr result depends only on Cr inputs.
- R3: Output line 0 reads chroma line 0 (c) from the stream, one sample per two pixels.
  - Pixel 2i is c[i].
  - Pixel 2i+1 is (c[i]+c[i+1]+1)>>1.
- R4: Right-edge duplication. On every line, the right neighbour of the last column is that column itself. The last pixel of a line never takes an input sample.
- R5: Kernel lines. Output line 2m+1, for m < CH_LINES-1, takes chroma line m+1 (b) from the stream and reads chroma line m (a) from the cache.
  - Pixel 2i is (a[i]+b[i]+1)>>1.
  - Pixel 2i+1 is (a[i]+a[i+1]+b[i]+b[i+1]+2)>>2.
- R6: Cache-only lines. Output line 2m, for m >= 1, is the R3 formula applied to cached chroma line m. `in_ready` stays 0 for the whole line, and an offered input sample is left untouched for the next fetched line.
- R7: Bottom-edge duplication. The last output line, 2*CH_LINES-1, equals the R3 formula applied to chroma line CH_LINES-1, taken from the cache without any input.
- R8: Frame wrap. After the last pixel of the frame, the next pixel is line 0 of a new frame, fetched again from the stream. Each frame consumes exactly `CH_LINES*OUT_W/2` input samples.
- R9: `out_valid` drops only when the current pixel needs a stream sample and `in_valid` is 0. In every other case it is 1.
- R10: No loss or repetition. An input sample is taken only in a cycle where an output pixel is transferred. While the output is blocked with unchanged input, `out_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input chroma sample offered |
| in_ready | output | 1 | Input sample taken this cycle when `in_valid` is also 1 |
| in_data | input | 2*SW | Input chroma pair, Cr in the upper half and Cb in the lower half |
| out_valid | output | 1 | Output pixel chroma available |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_data | output | 2*SW | Upsampled chroma pair, packed like `in_data` |

## Verification
The hardest situations to reach are those where backpressure meets the schedule boundaries. One is a blocked output while the line is waiting for a stream sample. Another is a cache-only line during which the input is already offering the first sample of the next fetched line. A third is the wrap from the duplicated last line into a new frame. The stimulus first runs one frame with no stalls. After that it randomly withholds `in_valid` and `out_ready`, and it keeps an offered sample pending across cache-only lines. The reference model recomputes every pixel from the full chroma frames by the formulas above and predicts `out_valid` and `in_ready` in every cycle. The frame data include alternating 0 and full-scale samples, so the rounding of both the two-tap and the four-tap averages is exercised in each component.

// File: rtl/chup_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the chroma upsampler.
// Assumes: nothing beyond the enum encoding being internal only.
package chup_pkg;

    // Role of the output line currently being produced
    typedef enum logic [1:0] {
        LN_FIRST  = 2'd0,   // line 0: stream only, written to cache
        LN_KERN   = 2'd1,   // odd line: cache (top) + stream (bottom)
        LN_DIRECT = 2'd2    // cache only, no input taken
    } line_kind_e;

endpackage

// File: rtl/chup_seq.sv
`timescale 1ns/1ps
// Module: chup_seq
// Walks the output frame pixel by pixel and tells the datapath which chroma
// column is needed, whether it must come from a fresh source (stream or
// cache) and what kind of line is being produced.
// Assumes: OUT_W even and >= 4; step pulses once per output transfer.
module chup_seq
    import chup_pkg::*;
#(
    parameter int OUT_W    = 16,
    parameter int CH_LINES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        step,
    output line_kind_e                  kind,
    output logic                        odd,
    output logic                        first_col,
    output logic                        need_src,
    output logic [$clog2(OUT_W/2)-1:0]  src_idx
);
    localparam int CW    = OUT_W / 2;
    localparam int OUT_H = 2 * CH_LINES;
    localparam int XW    = $clog2(OUT_W);
    localparam int LW    = (OUT_H > 2) ? $clog2(OUT_H) : 1;
    localparam int AW    = $clog2(CW);

    logic [XW-1:0] xcnt;
    logic [LW-1:0] ln;
    logic [AW-1:0] col;
    logic [AW:0]   nxt;
    logic          at_edge;

    // Pixel and line counters, advanced on every output transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xcnt <= '0;
            ln   <= '0;
        end else if (step) begin
            if (xcnt == XW'(OUT_W - 1)) begin
                xcnt <= '0;
                ln   <= (ln == LW'(OUT_H - 1)) ? '0 : ln + LW'(1);
            end else begin
                xcnt <= xcnt + XW'(1);
            end
        end
    end

    // Column selection and edge handling for the current pixel
    always_comb begin
        col       = xcnt[XW-1:1];
        odd       = xcnt[0];
        first_col = (xcnt == '0);
        nxt       = {1'b0, col} + (AW+1)'(1);
        at_edge   = (nxt == (AW+1)'(CW));
        need_src  = first_col || (odd && !at_edge);
        if (odd && !at_edge) src_idx = nxt[AW-1:0];
        else                 src_idx = col;
    end

    // Line role from the line counter
    always_comb begin
        if (ln == '0)                               kind = LN_FIRST;
        else if (ln[0] && (ln != LW'(OUT_H - 1)))   kind = LN_KERN;
        else                                        kind = LN_DIRECT;
    end

endmodule

// File: rtl/chup_cache.sv
`timescale 1ns/1ps
// Module: chup_cache
// One chroma line of storage with one write port and one asynchronous read
// port. A read of the address being written returns the old contents.
// Assumes: contents are never read before the line was written (guaranteed
// by the line schedule).
module chup_cache #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Store the fetched sample
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the cached sample of the requested column
    assign rdata = mem[raddr];

endmodule

// File: rtl/chup_kernel.sv
`timescale 1ns/1ps
// Module: chup_kernel
// Holds the current chroma column (top and bottom taps) and forms the
// rounded two- or four-tap average for each component of the pixel.
// Assumes: on single-line rows top and bottom carry the same sample, so the
// four-tap path reduces exactly to the horizontal two-tap average.
module chup_kernel #(
    parameter int SW = 8,
    parameter int NC = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           first_col,
    input  logic           odd,
    input  logic           need_src,
    input  logic [NC*SW-1:0] src_top,
    input  logic [NC*SW-1:0] src_bot,
    output logic [NC*SW-1:0] pix
);
    logic [NC*SW-1:0] hold_top;
    logic [NC*SW-1:0] hold_bot;

    // Capture the newly sourced column as the left column of the kernel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_top <= '0;
            hold_bot <= '0;
        end else if (load) begin
            hold_top <= src_top;
            hold_bot <= src_bot;
        end
    end

    for (genvar c = 0; c < NC; c++) begin : g_comp
        logic [SW-1:0] st, sb, ht, hb, nt, nb;
        logic [SW:0]   sum_src, sum_hold;
        logic [SW+1:0] sum_four;

        assign st = src_top[c*SW +: SW];
        assign sb = src_bot[c*SW +: SW];
        assign ht = hold_top[c*SW +: SW];
        assign hb = hold_bot[c*SW +: SW];
        // Right neighbour: fresh column, or the held one at the right edge
        assign nt = need_src ? st : ht;
        assign nb = need_src ? sb : hb;

        assign sum_src  = {1'b0, st} + {1'b0, sb} + (SW+1)'(1);
        assign sum_hold = {1'b0, ht} + {1'b0, hb} + (SW+1)'(1);
        assign sum_four = {2'b0, ht} + {2'b0, hb} + {2'b0, nt} + {2'b0, nb}
                        + (SW+2)'(2);

        assign pix[c*SW +: SW] = odd       ? SW'(sum_four >> 2) :
                                 first_col ? SW'(sum_src  >> 1) :
                                             SW'(sum_hold >> 1);
    end

endmodule

// File: rtl/chroma_upsampler.sv
`timescale 1ns/1ps
// Module: chroma_upsampler (top)
// Upsamples 2x2-subsampled Cb/Cr to one pair per output pixel in raster
// order, using a one-line cache so each chroma line is fetched once.
// Assumes: OUT_W even, 4..1024; input samples arrive in raster order of the
// chroma grid; in_ready depends combinationally on out_ready.
module chroma_upsampler
    import chup_pkg::*;
#(
    parameter int OUT_W    = 16,
    parameter int CH_LINES = 4,
    parameter int SW       = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [2*SW-1:0] in_data,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [2*SW-1:0] out_data
);
    localparam int CW = OUT_W / 2;
    localparam int DW = 2 * SW;
    localparam int AW = $clog2(CW);

    line_kind_e    kind;
    logic          odd, first_col, need_src, uses_stream, fire;
    logic [AW-1:0] src_idx;
    logic [DW-1:0] cache_rd, src_top, src_bot;

    chup_seq #(.OUT_W(OUT_W), .CH_LINES(CH_LINES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (fire),
        .kind      (kind),
        .odd       (odd),
        .first_col (first_col),
        .need_src  (need_src),
        .src_idx   (src_idx)
    );

    chup_cache #(.DW(DW), .DEPTH(CW), .AW(AW)) u_cache (
        .clk   (clk),
        .we    (fire && uses_stream),
        .waddr (src_idx),
        .wdata (in_data),
        .raddr (src_idx),
        .rdata (cache_rd)
    );

    // Route the column taps according to the line role
    always_comb begin
        case (kind)
            LN_FIRST: begin src_top = in_data;  src_bot = in_data;  end
            LN_KERN:  begin src_top = cache_rd; src_bot = in_data;  end
            default:  begin src_top = cache_rd; src_bot = cache_rd; end
        endcase
    end

    // Handshake: stall only when a stream sample is needed and absent
    always_comb begin
        uses_stream = need_src && (kind != LN_DIRECT);
        out_valid   = uses_stream ? in_valid : 1'b1;
        in_ready    = uses_stream && out_ready;
        fire        = out_valid && out_ready;
    end

    chup_kernel #(.SW(SW), .NC(2)) u_kernel (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (fire && need_src),
        .first_col (first_col),
        .odd       (odd),
        .need_src  (need_src),
        .src_top   (src_top),
        .src_bot   (src_bot),
        .pix       (out_data)
    );

endmodule

// File: rtl/chup_checker.sv
`timescale 1ns/1ps
// Module: chup_checker
// Port-level properties of the upsampler. Tracks the output position from
// observed transfers and relates it to the input handshake.
// Assumes: bound to chroma_upsampler with matching parameters.
module chup_checker #(
    parameter int OUT_W    = 16,
    parameter int CH_LINES = 4,
    parameter int DW       = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic [DW-1:0] in_data,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data
);
    localparam int OUT_H = 2 * CH_LINES;

    int  xc, lc;
    logic cache_line;

    // Output position counted from port transfers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xc <= 0;
            lc <= 0;
        end else if (out_valid && out_ready) begin
            if (xc == OUT_W - 1) begin
                xc <= 0;
                lc <= (lc == OUT_H - 1) ? 0 : lc + 1;
            end else begin
                xc <= xc + 1;
            end
        end
    end

    assign cache_line = (lc != 0) && ((lc % 2 == 0) || (lc == OUT_H - 1));

    // R9: a take from the input requires the sink to be ready
    a_r9_ready_needs_sink: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> out_ready);

    // R9: output stalls only because the input is empty
    a_r9_stall_only_on_input: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !in_valid);

    // R10: every input take coincides with an output transfer
    a_r10_take_with_emit: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (out_valid && out_ready));

    // R10: blocked output with unchanged input keeps its data
    a_r10_hold_while_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) ##1 (out_valid && $stable(in_data)) |-> $stable(out_data));

    // R6 and R7: cache-only lines never take input
    a_r6_cache_line_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        cache_line |-> !in_ready);

    // R4: the last pixel of a line is formed without a new sample
    a_r4_edge_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (xc == OUT_W - 1) |-> !in_ready);

    // R5: even pixels past column 0 reuse the held column
    a_r5_even_pixel_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        ((xc % 2 == 0) && (xc != 0)) |-> !in_ready);

endmodule

bind chroma_upsampler chup_checker #(
    .OUT_W(OUT_W), .CH_LINES(CH_LINES), .DW(2*SW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
);

// File: tb/chroma_upsampler_test.sv
`timescale 1ns/1ps
module chroma_upsampler_test;
    localparam int OUT_W = 16;
    localparam int CH    = 4;
    localparam int SW    = 8;
    localparam int DW    = 2 * SW;
    localparam int CW    = OUT_W / 2;
    localparam int OUT_H = 2 * CH;
    localparam int NF    = 3;
    localparam int NSRC  = NF * CH * CW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, in_ready, out_valid, out_ready;
    logic [DW-1:0] in_data, out_data;

    always #2.5 clk = ~clk;

    chroma_upsampler #(.OUT_W(OUT_W), .CH_LINES(CH), .SW(SW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    logic [DW-1:0] src [NSRC];
    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected pixel straight from the chroma frame and the line schedule
    function automatic logic [DW-1:0] model_pix(int f, int l, int x);
        int t, b, j, k, base, a0, a1, b0, b1;
        logic [DW-1:0] r;
        if (l == 0)              begin t = 0;          b = 0;          end
        else if (l == OUT_H - 1) begin t = CH - 1;     b = CH - 1;     end
        else if (l % 2 == 1)     begin t = (l - 1) / 2; b = (l + 1) / 2; end
        else                     begin t = l / 2;      b = l / 2;      end
        j = x / 2;
        k = (j + 1 < CW) ? j + 1 : CW - 1;
        base = f * CH * CW;
        for (int c = 0; c < 2; c++) begin
            a0 = int'(src[base + t*CW + j][c*SW +: SW]);
            a1 = int'(src[base + t*CW + k][c*SW +: SW]);
            b0 = int'(src[base + b*CW + j][c*SW +: SW]);
            b1 = int'(src[base + b*CW + k][c*SW +: SW]);
            if (x % 2 == 0) r[c*SW +: SW] = SW'((a0 + b0 + 1) / 2);
            else            r[c*SW +: SW] = SW'((a0 + a1 + b0 + b1 + 2) / 4);
        end
        return r;
    endfunction

    // Whether the pixel at (l, x) consumes a stream sample
    function automatic bit model_need(int l, int x);
        bit fetch_line = (l == 0) || ((l % 2 == 1) && (l != OUT_H - 1));
        bit fresh_col  = (x == 0) || ((x % 2 == 1) && (x / 2 + 1 < CW));
        return fetch_line && fresh_col;
    endfunction

    initial begin
        int mx, ml, mf, fi, cyc;
        bit pend, rnd, need;
        logic [DW-1:0] exp_pix;
        string tag;

        // Frame 0 random, frame 1 extremes for rounding, frame 2 ramps
        for (int f = 0; f < NF; f++)
            for (int l = 0; l < CH; l++)
                for (int c = 0; c < CW; c++) begin
                    logic [SW-1:0] cb, cr;
                    if (f == 0) begin
                        cb = SW'($urandom); cr = SW'($urandom);
                    end else if (f == 1) begin
                        cb = ((l + c) % 2 == 1) ? 8'hFF : 8'h00;
                        cr = (c % 3 == 0) ? 8'hFF : ((c % 3 == 1) ? 8'h01 : 8'h00);
                    end else begin
                        cb = SW'(c * 30 + l * 7);
                        cr = SW'(250 - c * 11 - l * 40);
                    end
                    src[f*CH*CW + l*CW + c] = {cr, cb};
                end

        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid idle", int'(out_valid), 0);

        mx = 0; ml = 0; mf = 0; fi = 0; cyc = 0; pend = 0;
        while (mf < NF) begin
            @(negedge clk);
            cyc++;
            if (cyc > 20000) begin
                checks++; errors++;
                $display("FAIL R8 watchdog: actual %0d frames expected %0d", mf, NF);
                break;
            end
            rnd = (fi >= CH * CW);
            if (!pend) begin
                if (fi < NSRC && (!rnd || $urandom_range(0, 3) != 0)) begin
                    in_valid = 1'b1; in_data = src[fi]; pend = 1;
                end else begin
                    in_valid = 1'b0; in_data = DW'($urandom);
                end
            end
            out_ready = rnd ? ($urandom_range(0, 2) != 0) : 1'b1;
            #1;
            need = model_need(ml, mx);
            chk(out_valid == (need ? in_valid : 1'b1), "R9", "out_valid",
                int'(out_valid), int'(need ? in_valid : 1'b1));
            chk(in_ready == (need && out_ready), "R10", "in_ready",
                int'(in_ready), int'(need && out_ready));
            if (out_valid && out_ready) begin
                exp_pix = model_pix(mf, ml, mx);
                if (mx == OUT_W - 1)           tag = "R4";
                else if (ml == 0)              tag = (mf > 0) ? "R8" : "R3";
                else if (ml == OUT_H - 1)      tag = "R7";
                else if (ml % 2 == 1)          tag = "R5";
                else                           tag = "R6";
                chk(out_data[SW-1:0] == exp_pix[SW-1:0], tag, "Cb",
                    int'(out_data[SW-1:0]), int'(exp_pix[SW-1:0]));
                chk(out_data[DW-1:SW] == exp_pix[DW-1:SW], "R2", "Cr",
                    int'(out_data[DW-1:SW]), int'(exp_pix[DW-1:SW]));
                if (in_valid && in_ready) begin
                    fi++; pend = 0;
                end
                mx++;
                if (mx == OUT_W) begin
                    mx = 0; ml++;
                    if (ml == OUT_H) begin
                        ml = 0; mf++;
                        chk(fi == mf * CH * CW, "R8", "samples per frame", fi, mf * CH * CW);
                    end
                end
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule